// File: doc/BRIEF.md
# Stream Correlation Match Counter

This block scores a sweep of trial wheel settings against a looped character tape. Each character arrives as a 5-bit value with a strobe taken from the tape's sprocket holes. Alongside it, five internal wheels produce a second 5-bit stream. Each wheel is a programmable pin pattern that steps one pin per strobe. For every character the block evaluates a selectable Boolean function of the two streams and counts how often it is true.

An end-of-tape pulse closes one pass over the tape. On that pulse the block does four things:
- it compares the count with a programmable threshold;
- it emits a score record when the count is strictly greater than the threshold;
- it clears the count;
- it moves every wheel's start position on by one pin.

The sweep covers as many trial offsets as the shortest selected wheel has pins. After the last offset the block raises `done` and then ignores the tape until it is restarted.

A `start` pulse latches the function select, the two channel selects and the threshold. The pin patterns must be held stable while a sweep runs. The block runs from a fast clock, and the tape strobe is an enable pulse that is one clock wide.

Top module: `corr_counter`

## Requirements
- R1: After reset `done` and `rpt_valid` are 0, and the block counts nothing until `start` is pulsed.
- R2: Wheel i has WLEN[i] pins (defaults 3, 4, 5, 6, 7). Pin p of wheel i is `pins[i*MAXL+p]` (MAXL defaults to 8). For trial offset t, the k-th strobed character of a pass meets pin (t+k) mod WLEN[i] of wheel i.
- R3: Let d = `ch` XOR wheel bits, with da = d[`sel_a`] and db = d[`sel_b`]. The character is a hit as follows:
  - `mode`=0: da==0
  - `mode`=1: da^db==0
  - `mode`=2: da==1
  - `mode`=3: da^db==1
- R4: A pulse on `eot` ends a pass. In the clock after it, `rpt_valid` is 1 for one cycle only if the pass's hit count is strictly greater than the latched threshold. In that cycle `rpt_offset` carries the trial offset and `rpt_score` carries the count.
- R5: After `eot` the count restarts at 0 and the trial offset rises by 1. The wheels restart from the new offset.
- R6: The hit count is 16 bits wide and holds at 65535 instead of wrapping.
- R7: The number of trial offsets is WLEN[`sel_a`] for modes 0 and 2. For modes 1 and 3 it is the smaller of WLEN[`sel_a`] and WLEN[`sel_b`].
- R8: After the last trial's `eot`, `done` goes to 1 in the same cycle as that trial's report. It stays 1 and strobes and `eot` have no effect until `start`.
- R9: A `start` pulse restarts the sweep at offset 0 with a cleared count, even during a sweep.
- R10: While `eot` is high, `strobe` is ignored; the end-of-tape marker carries no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch configuration and begin a sweep |
| mode | input | 2 | Function select (bit 0: two channels, bit 1: count mismatches) |
| sel_a | input | 3 | First channel, 0 to 4 |
| sel_b | input | 3 | Second channel, 0 to 4 |
| thresh | input | 16 | Report threshold (strictly greater reports) |
| pins | input | 40 | Wheel pin patterns, MAXL bits per wheel |
| strobe | input | 1 | Character strobe |
| ch | input | 5 | Tape character |
| eot | input | 1 | End-of-tape pulse |
| rpt_valid | output | 1 | Score record valid |
| rpt_offset | output | 4 | Trial offset of the record |
| rpt_score | output | 16 | Hit count of the record |
| done | output | 1 | Sweep finished |

## Verification
A character strobed at one edge is counted at that same edge. An `eot` sampled at an edge produces `rpt_valid`, `rpt_offset`, `rpt_score` and, on the last trial, `done` at that edge. The bench therefore drives every input on the falling edge. It raises `eot` one cycle after the last character and reads the record on the falling edge right after. Every pass is compared against an expected score that the bench computes from the pin patterns and the tape. Threshold equality and saturation are checked through the reported score.

// File: rtl/corr_counter.sv
module corr_counter #(
  parameter int CH = 5,
  parameter int MAXL = 8,
  parameter int WLEN [CH] = '{3, 4, 5, 6, 7},
  parameter int CNTW = 16,
  localparam int PW = $clog2(MAXL),
  localparam int TW = $clog2(MAXL + 1),
  localparam int SW = $clog2(CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [SW-1:0]     sel_a,
  input  logic [SW-1:0]     sel_b,
  input  logic [CNTW-1:0]   thresh,
  input  logic [CH*MAXL-1:0] pins,
  input  logic              strobe,
  input  logic [CH-1:0]     ch,
  input  logic              eot,
  output logic              rpt_valid,
  output logic [TW-1:0]     rpt_offset,
  output logic [CNTW-1:0]   rpt_score,
  output logic              done
);

  logic            busy;
  logic [1:0]      mode_q;
  logic [SW-1:0]   a_q, b_q;
  logic [CNTW-1:0] thr_q, count;
  logic [TW-1:0]   trial, ntr;
  logic [CH-1:0]   wbit;
  logic            hit;

  wire step = busy && strobe && !eot && !start;
  wire close = busy && eot && !start;

  for (genvar i = 0; i < CH; i++) begin : g_wheel
    logic [PW-1:0] sp, pos;
    wire [PW-1:0] last = PW'(WLEN[i] - 1);
    wire [PW-1:0] nsp = (sp == last) ? '0 : sp + 1'b1;
    assign wbit[i] = pins[i*MAXL + int'(pos)];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp  <= '0;
        pos <= '0;
      end else if (start) begin
        sp  <= '0;
        pos <= '0;
      end else if (close) begin
        sp  <= nsp;
        pos <= nsp;
      end else if (step) begin
        pos <= (pos == last) ? '0 : pos + 1'b1;
      end
    end
  end

  wire [CH-1:0] diff = ch ^ wbit;
  wire raw = mode_q[0] ? (diff[a_q] ^ diff[b_q]) : diff[a_q];
  assign hit = mode_q[1] ? raw : ~raw;

  wire [TW-1:0] len_a = TW'(WLEN[sel_a]);
  wire [TW-1:0] len_b = TW'(WLEN[sel_b]);
  wire [TW-1:0] n_trials = (mode[0] && len_b < len_a) ? len_b : len_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      mode_q <= '0;
      a_q <= '0;
      b_q <= '0;
      thr_q <= '0;
      count <= '0;
      trial <= '0;
      ntr <= '0;
      rpt_valid <= 1'b0;
      rpt_offset <= '0;
      rpt_score <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      mode_q <= mode;
      a_q <= sel_a;
      b_q <= sel_b;
      thr_q <= thresh;
      count <= '0;
      trial <= '0;
      ntr <= n_trials;
      rpt_valid <= 1'b0;
    end else begin
      rpt_valid <= 1'b0;
      if (close) begin
        rpt_valid <= count > thr_q;
        rpt_offset <= trial;
        rpt_score <= count;
        count <= '0;
        if (trial == ntr - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          trial <= trial + 1'b1;
        end
      end else if (step && hit && count != '1) begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/corr_counter_chk.sv
module corr_counter_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            strobe,
  input logic            eot,
  input logic            busy,
  input logic            done,
  input logic            hit,
  input logic            rpt_valid,
  input logic [CNTW-1:0] rpt_score,
  input logic [CNTW-1:0] thr_q,
  input logic [CNTW-1:0] count
);

  a_r4_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_score > thr_q);

  a_r4_after_eot: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(eot && busy && !start));

  a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eot && !start) |=> count == '0);

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && busy && strobe && hit && !eot && !start) |=> count == '1);

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && count == '0));

endmodule

bind corr_counter corr_counter_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe), .eot(eot),
  .busy(busy), .done(done), .hit(hit), .rpt_valid(rpt_valid),
  .rpt_score(rpt_score), .thr_q(thr_q), .count(count)
);

// File: tb/corr_counter_test.sv
module corr_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;
  localparam int LENS [5] = '{3, 4, 5, 6, 7};
  localparam logic [39:0] PINS = 40'h5B_E1_96_3C_A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [2:0] sel_a = '0, sel_b = '0;
  logic [15:0] thresh = '0;
  logic [39:0] pins = PINS;
  logic strobe = 1'b0;
  logic [4:0] ch = '0;
  logic eot = 1'b0;
  logic rpt_valid;
  logic [3:0] rpt_offset;
  logic [15:0] rpt_score;
  logic done;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_counter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sel_a(sel_a),
    .sel_b(sel_b), .thresh(thresh), .pins(pins), .strobe(strobe), .ch(ch),
    .eot(eot), .rpt_valid(rpt_valid), .rpt_offset(rpt_offset),
    .rpt_score(rpt_score), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] tape(input int k);
    return 5'(((k * 13 + 5) ^ (k * 3)) & 31);
  endfunction

  function automatic int exp_score(input int md, input int a, input int b, input int t);
    int s = 0;
    for (int k = 0; k < NCH; k++) begin
      logic [4:0] tc = tape(k);
      logic da = tc[a] ^ PINS[a*8 + (t + k) % LENS[a]];
      logic db = tc[b] ^ PINS[b*8 + (t + k) % LENS[b]];
      logic raw = md[0] ? (da ^ db) : da;
      if (md[1] ? raw : !raw) s++;
    end
    return s;
  endfunction

  task automatic pulse_start(input int md, input int a, input int b, input int thr);
    @(negedge clk);
    mode = 2'(md); sel_a = 3'(a); sel_b = 3'(b); thresh = 16'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_pass;
    for (int k = 0; k < NCH; k++) begin
      @(negedge clk);
      strobe = 1'b1; ch = tape(k);
    end
    @(negedge clk);
    strobe = 1'b1; eot = 1'b1;
    @(negedge clk);
    strobe = 1'b0; eot = 1'b0;
  endtask

  task automatic check_pass(input string req, input int md, input int a, input int b,
                            input int t, input int thr);
    int e = exp_score(md, a, b, t);
    run_pass();
    check({req, " R4 valid"}, int'(rpt_valid), int'(e > thr));
    if (e > thr) begin
      check({req, " R4 offset"}, int'(rpt_offset), t);
      check({req, " R2/R3 score"}, int'(rpt_score), e);
    end
  endtask

  task automatic sweep(input string req, input int md, input int a, input int b, input int ntr);
    int thr = exp_score(md, a, b, 0);
    pulse_start(md, a, b, thr);
    for (int t = 0; t < ntr; t++) begin
      check_pass(req, md, a, b, t, thr);
      check({req, " R8 done"}, int'(done), int'(t == ntr - 1));
    end
  endtask

  task automatic t_reset;
    check("R1 done", int'(done), 0);
    check("R1 rpt_valid", int'(rpt_valid), 0);
    run_pass();
    check("R1 idle no report", int'(rpt_valid), 0);
  endtask

  task automatic t_done_ignores;
    run_pass();
    check("R8 no report when done", int'(rpt_valid), 0);
    check("R8 done held", int'(done), 1);
  endtask

  task automatic t_restart;
    int thr = -1;
    pulse_start(0, 4, 4, 0);
    check_pass("R5 first", 0, 4, 4, 0, thr);
    check_pass("R5 second", 0, 4, 4, 1, thr);
    pulse_start(1, 4, 3, 0);
    check_pass("R9 restart offset0", 1, 4, 3, 0, 0);
    check("R9 not done", int'(done), 0);
  endtask

  task automatic t_eot_no_char;
    int e;
    pulse_start(0, 1, 1, 0);
    for (int k = 0; k < NCH; k++) begin
      @(negedge clk);
      strobe = 1'b1; ch = tape(k);
    end
    @(negedge clk);
    strobe = 1'b1; eot = 1'b1; ch = ~tape(NCH);
    @(negedge clk);
    strobe = 1'b0; eot = 1'b0;
    e = exp_score(0, 1, 1, 0);
    check("R10 eot carries no char", int'(rpt_score), e);
  endtask

  task automatic t_saturate;
    pins = '0;
    pulse_start(0, 0, 0, 0);
    @(negedge clk);
    strobe = 1'b1; ch = '0;
    repeat (70000) @(negedge clk);
    eot = 1'b1;
    @(negedge clk);
    strobe = 1'b0; eot = 1'b0;
    check("R6 saturated valid", int'(rpt_valid), 1);
    check("R6 saturated score", int'(rpt_score), 65535);
    pins = PINS;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    sweep("R3 mode0", 0, 2, 0, 5);
    t_done_ignores();
    sweep("R7 mode1 shorter b", 1, 4, 1, 4);
    sweep("R3 mode2", 2, 3, 3, 6);
    sweep("R7 mode3 shorter a", 3, 0, 2, 3);
    t_restart();
    t_eot_no_char();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule